// File: doc/BRIEF.md
# Two-Clock FIFO with Selectable Read Timing

This block moves 36-bit words from a write clock domain to an unrelated read clock domain through an inferred dual-port array. Each side has an active-low select and an active-high enable, and a word moves only on that side's rising clock edge when both are asserted. A static mode input chooses how the read side behaves. In standard timing a stored word stays in the array until an explicit read loads it into the output register. In fall-through timing the oldest word is moved to the output on its own and stays there until a read takes it.

Each side drives its own status flags from its own registers. The read side drives a data flag and an almost-empty flag. The write side drives a space flag and an almost-full flag. The almost flags compare against two offset inputs that come from outside the block. Pointers cross between the domains in Gray code through two synchronizer stages, so a flag always errs towards caution. Reset is one asynchronous active-low input. Each domain synchronizes it and counts its own edges, and a domain only starts working after a long enough reset.

Top module: `tm_async_fifo`

## Requirements
- R1: A word is written only on a write-clock rising edge with `wr_cs_n` low and `wr_en` high. A word is read only on a read-clock rising edge with `rd_cs_n` low and `rd_en` high. Any other combination leaves the stored contents and the output unchanged.
- R2: With `std_mode` high, a written word stays in the array and does not reach `rd_data`. A read edge taken while `rd_flag` is high places the oldest word on `rd_data`, and it is valid from that edge on. `rd_data` holds its value between reads.
- R3: With `std_mode` low, the oldest word appears on `rd_data` and `rd_flag` rises with no read request. It stays there until a read edge takes it, and then the next word (if any) replaces it.
- R4: Words leave in the order they were accepted, with none lost or duplicated, under any mix of write and read activity on the two clocks.
- R5: `wr_flag` (high = space available) drops once the FIFO holds its capacity, and writes are ignored while it is low. The capacity is DEPTH = 2^ADDR_W words in standard timing and DEPTH+1 in fall-through timing, where the output register adds one slot.
- R6: `ae_n` is low exactly when the word count seen by the read side is at or below `ae_offset`. In fall-through timing that count includes a word waiting on `rd_data`.
- R7: `af_n` is low exactly when the number of free array locations seen by the write side is at or below `af_offset`.
- R8: The read-side flags follow the write pointer through a two-stage synchronizer. `rd_flag` is never high in standard timing while the array is empty, and `wr_flag` is never high while the array is full.
- R9: After a complete reset, `wr_flag` is high, `rd_flag` is low, `ae_n` is low, and `af_n` is high when `af_offset` is below DEPTH.
- R10: A domain finishes reset only after four of its own clock edges see the synchronized reset low. After a shorter reset pulse, `wr_flag` and `rd_flag` stay low and writes are ignored until a complete reset.
- R11: `std_mode` high selects standard timing (`rd_flag` acts as not-empty) and low selects fall-through timing (`rd_flag` acts as output-ready). It is changed only while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| std_mode | input | 1 | 1 = standard read timing, 0 = fall-through timing |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Word to store |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read enable, active high |
| ae_offset | input | ADDR_W+1 | Almost-empty threshold |
| af_offset | input | ADDR_W+1 | Almost-full threshold |
| rd_data | output | DATA_W | Output register |
| rd_flag | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| ae_n | output | 1 | Almost-empty, active low |
| wr_flag | output | 1 | Not-full / input-ready, active high |
| af_n | output | 1 | Almost-full, active low |

## Verification
A read pointer that is off by one shows up as a wrong word on `rd_data` at the first read after the fault, in a different position in the queue model. A write pointer error shows up when that slot is drained. A fault in the Gray conversion or in the synchronizer corrupts the occupancy each side sees. The almost-flag sweep then reports a wrong `ae_n` or `af_n` within a few clocks of settling, and `wr_flag` fails to drop at exactly DEPTH (or DEPTH+1) accepted words. A broken reset counter shows up as flags rising after a short reset pulse.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // words between two wrapping pointers of pw bits
  function automatic logic [31:0] ring_used(input logic [31:0] w, input logic [31:0] r,
                                            input int unsigned pw);
    return (w - r) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/tmf_sync.sv
module tmf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk)
        if (clr) st[i] <= '0;
        else     st[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk)
        if (clr) st[i] <= '0;
        else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tmf_rst_gate.sv
module tmf_rst_gate #(
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic dom_clr,
  output logic dom_ok
);
  localparam int CW = $clog2(MIN_EDGES + 1);

  logic [1:0]    rs;
  logic          rs_prev;
  logic [CW-1:0] edges;

  always_ff @(posedge clk) begin
    rs      <= {rs[0], rst_n};
    rs_prev <= rs[1];
    if (!rs[1]) begin
      if (rs_prev)                         edges <= CW'(1);
      else if (edges != CW'(MIN_EDGES))    edges <= edges + CW'(1);
    end
  end

  assign dom_clr = !rs[1];
  assign dom_ok  = rs[1] && (edges == CW'(MIN_EDGES));
endmodule

// File: rtl/tmf_wr_side.sv
module tmf_wr_side
  import tmf_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            ok,
  input  logic            cs_n,
  input  logic            en,
  input  logic [ADDR_W:0] rptr_gray_in,
  input  logic [ADDR_W:0] af_off,
  output logic [ADDR_W:0] wptr,
  output logic [ADDR_W:0] wptr_gray,
  output logic [ADDR_W:0] rptr_seen,
  output logic            fire,
  output logic            wr_flag,
  output logic            af_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] rg_s, wptr_nx, used_nx, free_nx;

  tmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(clr), .d(rptr_gray_in), .q(rg_s));

  assign rptr_seen = PW'(from_gray(32'(rg_s)));
  assign fire      = ok & ~cs_n & en & wr_flag;
  assign wptr_nx   = wptr + PW'(fire);
  assign used_nx   = PW'(ring_used(32'(wptr_nx), 32'(rptr_seen), PW));
  assign free_nx   = PW'(DEPTH) - used_nx;

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr      <= '0;
      wptr_gray <= '0;
      wr_flag   <= 1'b0;
      af_n      <= 1'b1;
    end else begin
      wptr      <= wptr_nx;
      wptr_gray <= PW'(to_gray(32'(wptr_nx)));
      wr_flag   <= ok & (free_nx != '0);
      af_n      <= free_nx > af_off;
    end
  end
endmodule

// File: rtl/tmf_rd_side.sv
module tmf_rd_side
  import tmf_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            ok,
  input  logic            cs_n,
  input  logic            en,
  input  logic            std_mode,
  input  logic [ADDR_W:0] wptr_gray_in,
  input  logic [ADDR_W:0] ae_off,
  output logic [ADDR_W:0] rptr,
  output logic [ADDR_W:0] rptr_gray,
  output logic [ADDR_W:0] wptr_seen,
  output logic            pop,
  output logic            fire,
  output logic            rd_flag,
  output logic            ae_n
);
  localparam int PW = ADDR_W + 1;

  logic [ADDR_W:0] wg_s, rptr_nx, used_now, used_nx, stored_nx;
  logic            ov_nx, flag_nx;

  tmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(clr), .d(wptr_gray_in), .q(wg_s));

  assign wptr_seen = PW'(from_gray(32'(wg_s)));
  assign used_now  = PW'(ring_used(32'(wptr_seen), 32'(rptr), PW));
  assign fire      = ok & ~cs_n & en & rd_flag;
  // fall-through: refill the output register whenever it is free or being taken
  assign pop       = std_mode ? fire : (ok & (used_now != '0) & (~rd_flag | fire));
  assign rptr_nx   = rptr + PW'(pop);
  assign used_nx   = PW'(ring_used(32'(wptr_seen), 32'(rptr_nx), PW));
  assign ov_nx     = ~std_mode & (pop | (rd_flag & ~fire));
  assign flag_nx   = std_mode ? (used_nx != '0) : ov_nx;
  assign stored_nx = used_nx + PW'(ov_nx);

  always_ff @(posedge clk) begin
    if (clr) begin
      rptr      <= '0;
      rptr_gray <= '0;
      rd_flag   <= 1'b0;
      ae_n      <= 1'b0;
    end else begin
      rptr      <= rptr_nx;
      rptr_gray <= PW'(to_gray(32'(rptr_nx)));
      rd_flag   <= ok & flag_nx;
      ae_n      <= stored_nx > ae_off;
    end
  end
endmodule

// File: rtl/tm_async_fifo.sv
module tm_async_fifo #(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_EDGES   = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              std_mode,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_cs_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   ae_offset,
  input  logic [ADDR_W:0]   af_offset,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag,
  output logic              ae_n,
  output logic              wr_flag,
  output logic              af_n
);
  localparam int DEPTH = 1 << ADDR_W;

  logic            wr_clr, wr_ok, rd_clr, rd_ok;
  logic            wr_fire, rd_fire, rd_pop;
  logic [ADDR_W:0] wptr, wptr_gray, wr_rptr_b;
  logic [ADDR_W:0] rptr, rptr_gray, rd_wptr_b;
  logic [DATA_W-1:0] mem [DEPTH];

  tmf_rst_gate #(.MIN_EDGES(RST_EDGES)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .dom_clr(wr_clr), .dom_ok(wr_ok));
  tmf_rst_gate #(.MIN_EDGES(RST_EDGES)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .dom_clr(rd_clr), .dom_ok(rd_ok));

  tmf_wr_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk(wr_clk), .clr(wr_clr), .ok(wr_ok), .cs_n(wr_cs_n), .en(wr_en),
    .rptr_gray_in(rptr_gray), .af_off(af_offset), .wptr(wptr),
    .wptr_gray(wptr_gray), .rptr_seen(wr_rptr_b), .fire(wr_fire),
    .wr_flag(wr_flag), .af_n(af_n));

  tmf_rd_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk(rd_clk), .clr(rd_clr), .ok(rd_ok), .cs_n(rd_cs_n), .en(rd_en),
    .std_mode(std_mode), .wptr_gray_in(wptr_gray), .ae_off(ae_offset),
    .rptr(rptr), .rptr_gray(rptr_gray), .wptr_seen(rd_wptr_b), .pop(rd_pop),
    .fire(rd_fire), .rd_flag(rd_flag), .ae_n(ae_n));

  always_ff @(posedge wr_clk)
    if (wr_fire) mem[wptr[ADDR_W-1:0]] <= wr_data;

  always_ff @(posedge rd_clk)
    if (rd_pop) rd_data <= mem[rptr[ADDR_W-1:0]];
endmodule

// File: rtl/tmf_checker.sv
module tmf_checker
  import tmf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              std_mode,
  input logic              wr_cs_n,
  input logic              wr_en,
  input logic              wr_ok,
  input logic              rd_ok,
  input logic              wr_flag,
  input logic              rd_flag,
  input logic              rd_pop,
  input logic              rd_fire,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wptr,
  input logic [ADDR_W:0]   rptr,
  input logic [ADDR_W:0]   wr_rptr_b,
  input logic [ADDR_W:0]   rd_wptr_b
);
  localparam int PW = ADDR_W + 1;
  localparam logic [31:0] DEPTH = 32'd1 << ADDR_W;

  AST_WR_IDLE: assert property (@(posedge wr_clk) disable iff (!rst_n || !wr_ok)
    (wr_cs_n || !wr_en) |=> $stable(wptr)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n || !wr_ok)
    ring_used(32'(wptr), 32'(wr_rptr_b), PW) <= DEPTH); // R5
  AST_FULL_SAFE: assert property (@(posedge wr_clk) disable iff (!rst_n || !wr_ok)
    wr_flag |-> ring_used(32'(wptr), 32'(wr_rptr_b), PW) < DEPTH); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n || !rd_ok)
    ring_used(32'(rd_wptr_b), 32'(rptr), PW) <= DEPTH); // R8
  AST_EMPTY_SAFE: assert property (@(posedge rd_clk) disable iff (!rst_n || !rd_ok)
    (std_mode && rd_flag) |-> (rd_wptr_b != rptr)); // R8
  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n || !rd_ok)
    !rd_pop |=> $stable(rd_data)); // R2
  AST_OR_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n || !rd_ok)
    (!std_mode && rd_flag && !rd_fire) |=> (rd_flag && $stable(rd_data))); // R3
  AST_RST_QUIET: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ok |=> !wr_flag); // R10
endmodule

bind tm_async_fifo tmf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .std_mode(std_mode),
  .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_ok(wr_ok), .rd_ok(rd_ok),
  .wr_flag(wr_flag), .rd_flag(rd_flag), .rd_pop(rd_pop), .rd_fire(rd_fire),
  .rd_data(rd_data), .wptr(wptr), .rptr(rptr), .wr_rptr_b(wr_rptr_b),
  .rd_wptr_b(rd_wptr_b));

// File: tb/sim_tm_async_fifo.sv
`timescale 1ns/1ps
module sim_tm_async_fifo;
  localparam int DW = 36;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, std_mode = 1'b1;
  logic wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0] ae_offset = 4'd2, af_offset = 4'd2;
  logic [DW-1:0] rd_data;
  logic rd_flag, ae_n, wr_flag, af_n;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  tm_async_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .std_mode(std_mode),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .rd_cs_n(rd_cs_n),
    .rd_en(rd_en), .ae_offset(ae_offset), .af_offset(af_offset),
    .rd_data(rd_data), .rd_flag(rd_flag), .ae_n(ae_n), .wr_flag(wr_flag),
    .af_n(af_n));

  task automatic chk(input bit good, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return {4'(i), 32'(i) * 32'h0101_0101 + 32'h5A5A_0000};
  endfunction

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic full_reset(input logic mode);
    rst_n = 1'b0;
    std_mode = mode;
    repeat (10) @(posedge rd_clk);
    rst_n = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic push_one(input logic [DW-1:0] d, output bit took);
    @(negedge wr_clk);
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = d;
    took = wr_flag;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
    if (took) q.push_back(d);
  endtask

  task automatic std_read(input string req);
    bit had;
    logic [DW-1:0] e;
    @(negedge rd_clk);
    had = rd_flag;
    rd_cs_n = 1'b0; rd_en = 1'b1;
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
    if (had) begin
      e = q.pop_front();
      chk(rd_data == e, req, 64'(rd_data), 64'(e));
    end
  endtask

  task automatic fwft_read(input string req);
    logic [DW-1:0] e;
    @(negedge rd_clk);
    if (rd_flag) begin
      e = q.pop_front();
      chk(rd_data == e, req, 64'(rd_data), 64'(e));
      rd_cs_n = 1'b0; rd_en = 1'b1;
    end
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
  endtask

  task automatic stream(input int n, input logic mode);
    int got = 0;
    fork
      begin
        int i = 0, cyc = 0;
        while (i < n) begin
          @(negedge wr_clk);
          cyc++;
          if ((cyc % 3) != 1 && wr_flag) begin
            wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = pat(100 + i);
            q.push_back(pat(100 + i));
            i++;
          end else begin
            wr_cs_n = 1'b1; wr_en = 1'b0;
          end
        end
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
      end
      begin
        int cyc = 0;
        bit pend = 1'b0;
        logic [DW-1:0] e;
        while (got < n) begin
          @(negedge rd_clk);
          cyc++;
          if (mode) begin
            if (pend) begin
              e = q.pop_front();
              chk(rd_data == e, "R4 order std", 64'(rd_data), 64'(e));
              got++;
            end
            pend = rd_flag && ((cyc % 5) != 2);
            rd_cs_n = !pend; rd_en = pend;
          end else begin
            if (rd_flag && ((cyc % 5) != 2)) begin
              e = q.pop_front();
              chk(rd_data == e, "R4 order fwft", 64'(rd_data), 64'(e));
              got++;
              rd_cs_n = 1'b0; rd_en = 1'b1;
            end else begin
              rd_cs_n = 1'b1; rd_en = 1'b0;
            end
          end
        end
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b0;
      end
    join
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit took;
    int acc;
    // R9 reset state, standard timing
    full_reset(1'b1);
    chk(wr_flag == 1'b1, "R9 wr_flag", 64'(wr_flag), 64'd1);
    chk(rd_flag == 1'b0, "R9 rd_flag", 64'(rd_flag), 64'd0);
    chk(ae_n == 1'b0, "R9 ae_n", 64'(ae_n), 64'd0);
    chk(af_n == 1'b1, "R9 af_n", 64'(af_n), 64'd1);

    // R1: deselected or disabled writes do nothing
    @(negedge wr_clk); wr_cs_n = 1'b1; wr_en = 1'b1; wr_data = pat(1);
    @(negedge wr_clk); wr_cs_n = 1'b0; wr_en = 1'b0;
    @(negedge wr_clk); wr_cs_n = 1'b1;
    settle();
    chk(rd_flag == 1'b0, "R1 gated write", 64'(rd_flag), 64'd0);

    // R2 / R11: standard timing keeps the word inside until read
    push_one(pat(7), took);
    settle();
    chk(rd_flag == 1'b1, "R2 not empty", 64'(rd_flag), 64'd1);
    chk(rd_data != pat(7), "R11 no fall-through in standard", 64'(rd_data), 64'(pat(7)));
    // R1: deselected read leaves it in place
    @(negedge rd_clk); rd_cs_n = 1'b1; rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    settle();
    chk(rd_flag == 1'b1, "R1 gated read", 64'(rd_flag), 64'd1);
    chk(rd_data != pat(7), "R1 gated read data", 64'(rd_data), 64'(pat(7)));
    std_read("R2 read data");
    settle();
    chk(rd_flag == 1'b0, "R2 empty after read", 64'(rd_flag), 64'd0);

    // R5: standard capacity
    acc = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      push_one(pat(20 + i), took);
      acc += int'(took);
    end
    chk(acc == DEPTH, "R5 std capacity", 64'(acc), 64'(DEPTH));
    chk(wr_flag == 1'b0, "R5 full", 64'(wr_flag), 64'd0);
    settle();
    for (int i = 0; i < DEPTH; i++) std_read("R4 std drain");
    settle();
    chk(rd_flag == 1'b0, "R5 drained", 64'(rd_flag), 64'd0);
    chk(wr_flag == 1'b1, "R5 space back", 64'(wr_flag), 64'd1);

    // R6 / R7: sweep occupancy and offsets
    full_reset(1'b1);
    for (int k = 0; k <= DEPTH; k++) begin
      if (k > 0) push_one(pat(40 + k), took);
      settle();
      for (int off = 0; off <= DEPTH; off++) begin
        ae_offset = 4'(off); af_offset = 4'(off);
        repeat (3) @(negedge rd_clk);
        repeat (3) @(negedge wr_clk);
        chk(ae_n == (k > off), "R6 almost-empty", 64'(ae_n), 64'(k > off));
        chk(af_n == ((DEPTH - k) > off), "R7 almost-full", 64'(af_n),
            64'((DEPTH - k) > off));
      end
    end
    ae_offset = 4'd2; af_offset = 4'd2;

    // R3 / R11: fall-through timing
    full_reset(1'b0);
    chk(rd_flag == 1'b0, "R9 fwft rd_flag", 64'(rd_flag), 64'd0);
    chk(wr_flag == 1'b1, "R9 fwft wr_flag", 64'(wr_flag), 64'd1);
    push_one(pat(60), took);
    settle();
    chk(rd_flag == 1'b1, "R3 output ready", 64'(rd_flag), 64'd1);
    chk(rd_data == pat(60), "R3 fall-through", 64'(rd_data), 64'(pat(60)));
    push_one(pat(61), took);
    settle();
    chk(rd_data == pat(60), "R3 held without read", 64'(rd_data), 64'(pat(60)));
    fwft_read("R3 first word");
    settle();
    chk(rd_data == pat(61), "R3 next word", 64'(rd_data), 64'(pat(61)));
    fwft_read("R3 second word");
    settle();
    chk(rd_flag == 1'b0, "R3 not ready", 64'(rd_flag), 64'd0);

    // R5 / R6: fall-through capacity includes the output register
    push_one(pat(70), took);
    settle();
    acc = 1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      push_one(pat(71 + i), took);
      acc += int'(took);
    end
    chk(acc == DEPTH + 1, "R5 fwft capacity", 64'(acc), 64'(DEPTH + 1));
    ae_offset = 4'(DEPTH);
    settle();
    chk(ae_n == 1'b1, "R6 fwft count includes output", 64'(ae_n), 64'd1);
    ae_offset = 4'd2;
    for (int i = 0; i < DEPTH + 1; i++) fwft_read("R4 fwft drain");
    settle();
    chk(rd_flag == 1'b0, "R5 fwft drained", 64'(rd_flag), 64'd0);

    // R4: concurrent traffic in both timings
    stream(60, 1'b0);
    full_reset(1'b1);
    stream(60, 1'b1);
    settle();
    chk(q.size() == 0, "R4 no leftovers", 64'(q.size()), 64'd0);

    // R10: short reset pulse leaves the block disabled
    rst_n = 1'b0;
    #20;
    rst_n = 1'b1;
    settle();
    chk(wr_flag == 1'b0, "R10 wr_flag held", 64'(wr_flag), 64'd0);
    push_one(pat(90), took);
    chk(took == 1'b0, "R10 write refused", 64'(took), 64'd0);
    settle();
    chk(rd_flag == 1'b0, "R10 rd_flag held", 64'(rd_flag), 64'd0);
    full_reset(1'b1);
    chk(wr_flag == 1'b1, "R10 full reset recovers", 64'(wr_flag), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule